// File: doc/BRIEF.md
# ADC calibration sequence controller

This block sequences the calibration steps of an oversampling converter core. A host requests a step by holding a calibration request pin high for a minimum number of master-clock cycles and then releasing it. A two-bit mode code, sampled when the request rises, chooses one of four step types. Each step type has its own fixed duration and its own set of endpoints to record.

While a step runs, the block holds busy and an active-low data-ready flag high. When the step ends, it emits one-cycle strobes that tell the converter datapath which points to record and where each point comes from. The strobes also tell the datapath whether to overwrite the output word with all zeros or all ones.

The block enforces two rules. A two-step gain step is rejected unless an offset step has completed before it. Any change of the polarity select input cancels the calibration state, including a step that is running. Durations are parameters, so a bench can run shortened steps.

Top module: `adc_cal_sequencer`

## Requirements
- R1: A request is accepted only if calReq was sampled high on at least MIN_HIGH consecutive clock edges. A shorter pulse has no effect. An accepted step starts at the first edge that samples calReq low, and busy is 1 from the following cycle.
- R2: modeSel is captured on the edge where calReq is first sampled high. Later changes of modeSel before release do not change the step type. modeSel[1] is the first select bit and modeSel[0] is the second.
- R3: Code 00 is self-calibration. busy stays high for DUR_SELF cycles. At the end, capZero and capFull pulse with zeroFromAin=0 and fullFromAin=0, and neither force output is set.
- R4: Code 11 is the first step of a two-step system calibration (offset). busy lasts DUR_SYS_OFS cycles. At the end, capZero pulses with zeroFromAin=1, capFull stays 0, and forceZero pulses. A completed step of this type is recorded as a finished offset step.
- R5: Code 01 is the second step of a two-step system calibration (gain). busy lasts DUR_SYS_GAIN cycles. At the end, capFull pulses with fullFromAin=1, capZero stays 0, and forceOnes pulses.
- R6: Code 10 is a one-step system offset. busy lasts DUR_ONE_OFS cycles. At the end, capZero pulses with zeroFromAin=1, capFull pulses with fullFromAin=0, and forceZero pulses.
- R7: While busy is 1, rdyN is 1. In the cycle after the last busy cycle, busy and rdyN are both 0 and the end strobes are high for exactly one cycle. Requests that are released while busy is 1 are ignored.
- R8: forceZero and forceOnes are never high together. Neither is high outside the end-of-step cycle.
- R9: A gain request (code 01) with no completed code-11 step since reset or since the last polarity change is rejected. seqErr pulses for one cycle, busy stays 0 and rdyN keeps its value.
- R10: A change of bipolarSel cancels a running step. In the next cycle busy is 0, rdyN is 1 and no end strobe is given. The change also clears the completed-offset record. A request released in the same cycle as the change is dropped.
- R11: During and right after reset, busy=0, rdyN=1, and all strobes and seqErr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| calReq | input | 1 | Calibration request, active high, step starts on release |
| modeSel | input | 2 | Step type code, captured when calReq rises |
| bipolarSel | input | 1 | Polarity select, not latched; any change cancels calibration |
| rdyN | output | 1 | Data-not-ready flag, high during a step and until the first completion |
| busy | output | 1 | A calibration step is running |
| capZero | output | 1 | One-cycle strobe: record the zero-scale point |
| capFull | output | 1 | One-cycle strobe: record the full-scale point |
| zeroFromAin | output | 1 | With capZero: zero point comes from the analog input (else ground) |
| fullFromAin | output | 1 | With capFull: full point comes from the analog input (else reference) |
| forceZero | output | 1 | One-cycle strobe: overwrite output word with all zeros |
| forceOnes | output | 1 | One-cycle strobe: overwrite output word with all ones |
| seqErr | output | 1 | One-cycle pulse: gain request rejected for missing offset step |

## Verification
On every cycle the assertions check several properties. Each step starts only after a request pulse of at least the minimum width. Each of the four step types runs exactly its own duration, measured by a counter in the checker. busy always implies rdyN, and end strobes appear only in the cycle that busy falls. The two force outputs are exclusive, a rejection leaves busy and rdyN unchanged, and a polarity change ends a running step without strobes. Some behaviours can only be shown by the directed scenarios in the bench. These are the mode capture at the rising edge despite later mode changes, a short pulse producing nothing, and a request during a step being lost rather than queued. The scenarios also show that a polarity change wipes the offset record, so a later gain step is refused.

// File: rtl/cal_seq_pkg.sv
`timescale 1ns/1ps
package cal_seq_pkg;

  // Step type code: bit 1 = first select, bit 0 = second select
  typedef enum logic [1:0] {
    CAL_SELF     = 2'b00,
    CAL_SYS_GAIN = 2'b01,
    CAL_ONE_OFS  = 2'b10,
    CAL_SYS_OFS  = 2'b11
  } calCode_e;

  // Control -> datapath strobes
  typedef struct packed {
    logic     load;   // start the step timer
    logic     stop;   // cancel the step timer
    calCode_e code;   // step whose duration is loaded
  } ctrlCmd_t;

  // Datapath -> control status
  typedef struct packed {
    logic     startReq;   // qualified request released, timer idle
    logic     timerDone;  // last cycle of the running step
    logic     bpChange;   // polarity input differs from last cycle
    calCode_e code;       // code captured at request rise
  } dpStat_t;

endpackage

// File: rtl/cal_seq_dp.sv
`timescale 1ns/1ps
module cal_seq_dp
  import cal_seq_pkg::*;
#(
  parameter int unsigned MIN_HIGH     = 4,
  parameter int unsigned DUR_SELF     = 3145655,
  parameter int unsigned DUR_SYS_OFS  = 1052599,
  parameter int unsigned DUR_SYS_GAIN = 1068813,
  parameter int unsigned DUR_ONE_OFS  = 2117389
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       calReq,
  input  logic [1:0] modeSel,
  input  logic       bipolarSel,
  input  ctrlCmd_t   cmd,
  output dpStat_t    stat
);

  localparam int unsigned MAX_A   = (DUR_SELF > DUR_SYS_OFS) ? DUR_SELF : DUR_SYS_OFS;
  localparam int unsigned MAX_B   = (DUR_SYS_GAIN > DUR_ONE_OFS) ? DUR_SYS_GAIN : DUR_ONE_OFS;
  localparam int unsigned MAX_DUR = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W   = (MAX_DUR > 1) ? $clog2(MAX_DUR) : 1;
  localparam int unsigned HI_W    = $clog2(MIN_HIGH + 1);
  localparam logic [HI_W-1:0] HI_SAT = HI_W'(MIN_HIGH);

  logic             calQ;
  logic             bpQ;
  logic [HI_W-1:0]  highCnt;
  calCode_e         codeQ;
  logic [CNT_W-1:0] stepCnt;
  logic [CNT_W-1:0] loadVal;
  logic             running;
  logic             reqRise;
  logic             reqFall;

  assign reqRise = calReq & ~calQ;
  assign reqFall = ~calReq & calQ;

  // Request pulse width measurement and mode capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calQ    <= 1'b0;
      highCnt <= '0;
      codeQ   <= CAL_SELF;
    end else begin
      calQ <= calReq;
      if (reqRise) begin
        highCnt <= HI_W'(1);
      end else if (calReq && (highCnt != HI_SAT)) begin
        highCnt <= highCnt + 1'b1;
      end
      if (reqRise && !running) begin
        codeQ <= calCode_e'(modeSel);
      end
    end
  end

  // Polarity history, free running so it is valid once reset ends
  always_ff @(posedge clk) begin
    bpQ <= bipolarSel;
  end

  // Duration selection per step type
  always_comb begin
    unique case (cmd.code)
      CAL_SELF:     loadVal = CNT_W'(DUR_SELF - 1);
      CAL_SYS_OFS:  loadVal = CNT_W'(DUR_SYS_OFS - 1);
      CAL_SYS_GAIN: loadVal = CNT_W'(DUR_SYS_GAIN - 1);
      default:      loadVal = CNT_W'(DUR_ONE_OFS - 1);
    endcase
  end

  // Step timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt <= '0;
      running <= 1'b0;
    end else if (cmd.stop) begin
      running <= 1'b0;
    end else if (cmd.load) begin
      running <= 1'b1;
      stepCnt <= loadVal;
    end else if (running) begin
      if (stepCnt == '0) begin
        running <= 1'b0;
      end else begin
        stepCnt <= stepCnt - 1'b1;
      end
    end
  end

  always_comb begin
    stat.startReq  = reqFall && (highCnt >= HI_SAT) && !running;
    stat.timerDone = running && (stepCnt == '0);
    stat.bpChange  = (bipolarSel != bpQ);
    stat.code      = codeQ;
  end

endmodule

// File: rtl/cal_seq_ctrl.sv
`timescale 1ns/1ps
module cal_seq_ctrl
  import cal_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  dpStat_t  stat,
  output ctrlCmd_t cmd,
  output logic     busy,
  output logic     rdyN,
  output logic     capZero,
  output logic     capFull,
  output logic     zeroFromAin,
  output logic     fullFromAin,
  output logic     forceZero,
  output logic     forceOnes,
  output logic     seqErr
);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e   state;
  calCode_e activeCode;
  logic     offsetDone;
  logic     accept;

  assign accept = (stat.code != CAL_SYS_GAIN) || offsetDone;
  assign busy   = (state == ST_RUN);

  always_comb begin
    cmd.load = (state == ST_IDLE) && stat.startReq && !stat.bpChange && accept;
    cmd.stop = (state == ST_RUN) && stat.bpChange;
    cmd.code = stat.code;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      activeCode  <= CAL_SELF;
      offsetDone  <= 1'b0;
      rdyN        <= 1'b1;
      capZero     <= 1'b0;
      capFull     <= 1'b0;
      zeroFromAin <= 1'b0;
      fullFromAin <= 1'b0;
      forceZero   <= 1'b0;
      forceOnes   <= 1'b0;
      seqErr      <= 1'b0;
    end else begin
      capZero     <= 1'b0;
      capFull     <= 1'b0;
      zeroFromAin <= 1'b0;
      fullFromAin <= 1'b0;
      forceZero   <= 1'b0;
      forceOnes   <= 1'b0;
      seqErr      <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (stat.bpChange) begin
            offsetDone <= 1'b0;
            rdyN       <= 1'b1;
          end else if (stat.startReq) begin
            if (accept) begin
              state      <= ST_RUN;
              activeCode <= stat.code;
              rdyN       <= 1'b1;
            end else begin
              seqErr <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (stat.bpChange) begin
            state      <= ST_IDLE;
            offsetDone <= 1'b0;
            rdyN       <= 1'b1;
          end else if (stat.timerDone) begin
            state <= ST_IDLE;
            rdyN  <= 1'b0;
            unique case (activeCode)
              CAL_SELF: begin
                capZero <= 1'b1;
                capFull <= 1'b1;
              end
              CAL_SYS_OFS: begin
                capZero     <= 1'b1;
                zeroFromAin <= 1'b1;
                forceZero   <= 1'b1;
                offsetDone  <= 1'b1;
              end
              CAL_SYS_GAIN: begin
                capFull     <= 1'b1;
                fullFromAin <= 1'b1;
                forceOnes   <= 1'b1;
              end
              default: begin
                capZero     <= 1'b1;
                capFull     <= 1'b1;
                zeroFromAin <= 1'b1;
                forceZero   <= 1'b1;
              end
            endcase
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_cal_sequencer.sv
`timescale 1ns/1ps
module adc_cal_sequencer
  import cal_seq_pkg::*;
#(
  parameter int unsigned MIN_HIGH     = 4,
  parameter int unsigned DUR_SELF     = 3145655,
  parameter int unsigned DUR_SYS_OFS  = 1052599,
  parameter int unsigned DUR_SYS_GAIN = 1068813,
  parameter int unsigned DUR_ONE_OFS  = 2117389
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       calReq,
  input  logic [1:0] modeSel,
  input  logic       bipolarSel,
  output logic       rdyN,
  output logic       busy,
  output logic       capZero,
  output logic       capFull,
  output logic       zeroFromAin,
  output logic       fullFromAin,
  output logic       forceZero,
  output logic       forceOnes,
  output logic       seqErr
);

  ctrlCmd_t cmd;
  dpStat_t  stat;

  cal_seq_dp #(
    .MIN_HIGH    (MIN_HIGH),
    .DUR_SELF    (DUR_SELF),
    .DUR_SYS_OFS (DUR_SYS_OFS),
    .DUR_SYS_GAIN(DUR_SYS_GAIN),
    .DUR_ONE_OFS (DUR_ONE_OFS)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .calReq    (calReq),
    .modeSel   (modeSel),
    .bipolarSel(bipolarSel),
    .cmd       (cmd),
    .stat      (stat)
  );

  cal_seq_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .stat       (stat),
    .cmd        (cmd),
    .busy       (busy),
    .rdyN       (rdyN),
    .capZero    (capZero),
    .capFull    (capFull),
    .zeroFromAin(zeroFromAin),
    .fullFromAin(fullFromAin),
    .forceZero  (forceZero),
    .forceOnes  (forceOnes),
    .seqErr     (seqErr)
  );

endmodule

// File: rtl/adc_cal_sequencer_chk.sv
`timescale 1ns/1ps
module adc_cal_sequencer_chk #(
  parameter int unsigned MIN_HIGH     = 4,
  parameter int unsigned DUR_SELF     = 3145655,
  parameter int unsigned DUR_SYS_OFS  = 1052599,
  parameter int unsigned DUR_SYS_GAIN = 1068813,
  parameter int unsigned DUR_ONE_OFS  = 2117389
) (
  input logic       clk,
  input logic       rstN,
  input logic       calReq,
  input logic [1:0] modeSel,
  input logic       bipolarSel,
  input logic       rdyN,
  input logic       busy,
  input logic       capZero,
  input logic       capFull,
  input logic       zeroFromAin,
  input logic       fullFromAin,
  input logic       forceZero,
  input logic       forceOnes,
  input logic       seqErr
);

  localparam int unsigned HI_W = $clog2(MIN_HIGH + 1);
  localparam logic [HI_W-1:0] HI_SAT = HI_W'(MIN_HIGH);

  logic [HI_W-1:0] runLen;
  int unsigned     busyLen;
  logic [1:0]      modeSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen   <= '0;
      busyLen  <= 0;
      modeSeen <= '0;
    end else begin
      modeSeen <= modeSel;
      if (!calReq) runLen <= '0;
      else if (runLen != HI_SAT) runLen <= runLen + 1'b1;
      if (busy) busyLen <= busyLen + 1;
      else busyLen <= 0;
    end
  end

  assert_start_width_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (!$past(calReq) && ($past(runLen) >= HI_SAT)));

  assert_self_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    (capZero && capFull && !zeroFromAin) |-> (busyLen == DUR_SELF));

  assert_sys_ofs_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    (capZero && !capFull) |-> (busyLen == DUR_SYS_OFS && zeroFromAin && forceZero));

  assert_gain_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    (capFull && !capZero) |-> (busyLen == DUR_SYS_GAIN && fullFromAin && forceOnes));

  assert_one_ofs_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    (capZero && capFull && zeroFromAin) |-> (busyLen == DUR_ONE_OFS && !fullFromAin));

  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> rdyN);

  assert_strobe_at_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    (capZero || capFull || forceZero || forceOnes) |-> (!busy && $past(busy) && !rdyN));

  assert_force_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    (forceZero || forceOnes) |-> (forceZero != forceOnes));

  assert_reject_R9: assert property (@(posedge clk) disable iff (!rstN)
    seqErr |-> (!busy && rdyN == $past(rdyN) && $past(modeSeen) == 2'b01));

  assert_bp_abort_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && bipolarSel != $past(bipolarSel)) |=> (!busy && rdyN && !capZero && !capFull));

endmodule

bind adc_cal_sequencer adc_cal_sequencer_chk #(
  .MIN_HIGH    (MIN_HIGH),
  .DUR_SELF    (DUR_SELF),
  .DUR_SYS_OFS (DUR_SYS_OFS),
  .DUR_SYS_GAIN(DUR_SYS_GAIN),
  .DUR_ONE_OFS (DUR_ONE_OFS)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .calReq     (calReq),
  .modeSel    (modeSel),
  .bipolarSel (bipolarSel),
  .rdyN       (rdyN),
  .busy       (busy),
  .capZero    (capZero),
  .capFull    (capFull),
  .zeroFromAin(zeroFromAin),
  .fullFromAin(fullFromAin),
  .forceZero  (forceZero),
  .forceOnes  (forceOnes),
  .seqErr     (seqErr)
);

// File: tb/tb_adc_cal_sequencer.sv
`timescale 1ns/1ps
module tb_adc_cal_sequencer;

  localparam int MIN_HIGH = 4;
  localparam int D_SELF   = 40;
  localparam int D_SOFS   = 12;
  localparam int D_GAIN   = 17;
  localparam int D_OOFS   = 25;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       calReq = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       bipolarSel = 1'b0;
  logic rdyN, busy, capZero, capFull, zeroFromAin, fullFromAin;
  logic forceZero, forceOnes, seqErr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_cal_sequencer #(
    .MIN_HIGH    (MIN_HIGH),
    .DUR_SELF    (D_SELF),
    .DUR_SYS_OFS (D_SOFS),
    .DUR_SYS_GAIN(D_GAIN),
    .DUR_ONE_OFS (D_OOFS)
  ) dut (
    .clk(clk), .rstN(rstN), .calReq(calReq), .modeSel(modeSel),
    .bipolarSel(bipolarSel), .rdyN(rdyN), .busy(busy), .capZero(capZero),
    .capFull(capFull), .zeroFromAin(zeroFromAin), .fullFromAin(fullFromAin),
    .forceZero(forceZero), .forceOnes(forceOnes), .seqErr(seqErr)
  );

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int strobes();
    return {capZero, capFull, zeroFromAin, fullFromAin, forceZero, forceOnes};
  endfunction

  // Hold calReq for hi edges; modeSel switches to lateCode after the rise edge
  task automatic pulseCal(input logic [1:0] code, input int hi, input logic [1:0] lateCode);
    @(negedge clk); modeSel = code; calReq = 1'b1;
    @(negedge clk); modeSel = lateCode;
    repeat (hi - 1) @(negedge clk);
    calReq = 1'b0;
  endtask

  // Full step with exact duration and end strobes {cz,cf,za,fa,fz,fo}
  task automatic runStep(input logic [1:0] code, input int dur, input int expStrb,
                         input string tag);
    pulseCal(code, MIN_HIGH, ~code);
    @(negedge clk);
    chk({tag, " busy after release"}, busy, 1);
    chk({tag, " rdyN during step"}, rdyN, 1);
    repeat (dur - 1) @(negedge clk);
    chk({tag, " busy in last cycle"}, busy, 1);
    chk({tag, " no strobe before end"}, strobes(), 0);
    @(negedge clk);
    chk({tag, " busy cleared"}, busy, 0);
    chk({tag, " rdyN low after end"}, rdyN, 0);
    chk({tag, " end strobes"}, strobes(), expStrb);
    @(negedge clk);
    chk({tag, " strobes one cycle"}, strobes(), 0);
  endtask

  task automatic tReset();
    chk("R11 busy at reset", busy, 0);
    chk("R11 rdyN at reset", rdyN, 1);
    chk("R11 strobes at reset", strobes(), 0);
    chk("R11 seqErr at reset", seqErr, 0);
  endtask

  task automatic tShortPulse();
    int seen = 0;
    pulseCal(2'b00, MIN_HIGH - 1, 2'b00);
    repeat (8) begin
      @(negedge clk);
      if (busy) seen++;
    end
    chk("R1 short pulse ignored", seen, 0);
    chk("R1 rdyN unchanged", rdyN, 1);
  endtask

  task automatic tGainEarly();
    pulseCal(2'b01, MIN_HIGH, 2'b01);
    @(negedge clk);
    chk("R9 seqErr pulse", seqErr, 1);
    chk("R9 busy stays low", busy, 0);
    chk("R9 rdyN unchanged", rdyN, 1);
    @(negedge clk);
    chk("R9 seqErr one cycle", seqErr, 0);
  endtask

  task automatic tBusyIgnore();
    int n;
    pulseCal(2'b00, MIN_HIGH, 2'b00);
    @(negedge clk);
    pulseCal(2'b01, MIN_HIGH, 2'b01);  // released while busy
    n = 6;
    @(negedge clk);
    while (busy) begin
      n++;
      @(negedge clk);
    end
    chk("R7 step length unchanged by request", n, D_SELF);
    n = 0;
    repeat (6) begin
      @(negedge clk);
      if (busy || seqErr) n++;
    end
    chk("R7 request during step dropped", n, 0);
  endtask

  task automatic tBpAbort();
    int n = 0;
    pulseCal(2'b11, MIN_HIGH, 2'b11);
    repeat (3) @(negedge clk);
    chk("R10 running before toggle", busy, 1);
    bipolarSel = ~bipolarSel;
    @(negedge clk);
    chk("R10 busy cleared by toggle", busy, 0);
    chk("R10 rdyN high after toggle", rdyN, 1);
    repeat (D_SOFS + 3) begin
      @(negedge clk);
      if (strobes() != 0 || busy) n++;
    end
    chk("R10 no strobes after abort", n, 0);
  endtask

  task automatic tBpClearsOffset();
    runStep(2'b11, D_SOFS, 6'b101010, "R4 before toggle");
    bipolarSel = ~bipolarSel;
    @(negedge clk);
    chk("R10 rdyN raised by toggle", rdyN, 1);
    pulseCal(2'b01, MIN_HIGH, 2'b01);
    @(negedge clk);
    chk("R10 gain refused after toggle", seqErr, 1);
    chk("R10 gain not started", busy, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tShortPulse();
    tGainEarly();
    runStep(2'b00, D_SELF, 6'b110000, "R3 R1 R2 self");
    runStep(2'b11, D_SOFS, 6'b101010, "R4 R2 R8 sys offset");
    runStep(2'b01, D_GAIN, 6'b010101, "R5 R8 sys gain");
    runStep(2'b01, D_GAIN, 6'b010101, "R5 repeat gain");
    runStep(2'b10, D_OOFS, 6'b111010, "R6 R8 one-step offset");
    tBusyIgnore();
    tBpAbort();
    tBpClearsOffset();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule